// File: doc/BRIEF.md
# Millisecond Real-Time Clock with Seconds Snapshot

This block keeps wall time as a 32-bit seconds count and a milliseconds-within-second count. It is fed by a one-cycle enable pulse, `src_tick`, that marks each period of an always-on 32.768 kHz source. A fractional accumulator turns those pulses into millisecond ticks. For each source pulse it adds 1000. When the sum reaches 32768 it emits a tick and subtracts 32768. Over 32768 pulses it produces exactly 1000 ticks, so the clock does not drift.

Software reaches the clock over a simple single-cycle register bus. It may read the live seconds, the snapshot seconds or the milliseconds. Reading the milliseconds copies the live seconds into the snapshot register in the same cycle. Software reads milliseconds first and snapshot seconds second, then forms seconds*1000 + milliseconds with no tearing at a seconds rollover. The snapshot register is a single shared resource. Two agents that interleave their read pairs overwrite each other's capture. Writing the live seconds sets the time and restarts the sub-second phase.

Top module: `ms_rtc`

## Requirements
- R1: After the asynchronous active-low reset, live seconds, snapshot seconds, milliseconds and the fractional phase are all zero, and reads of every register return 0.
- R2: After N source pulses since reset or since the last seconds write, the elapsed millisecond count is floor(N*1000/32768). The first millisecond therefore appears on the 33rd pulse, not the 32nd.
- R3: The milliseconds count runs from 0 to 999. The tick that would take it past 999 returns it to 0 and adds one to the seconds.
- R4: The seconds count is 32 bits wide and rolls from 0xFFFFFFFF to 0 without any other effect.
- R5: A bus read (sel=1, wr=0) returns the addressed register on `bus_rdata` one cycle later, and `bus_rdata` holds between reads. The offsets are: live seconds 0x08, snapshot seconds 0x0C, milliseconds 0x10.
- R6: A read at 0x10 copies the live seconds into the snapshot register on the same clock edge. The snapshot then keeps that value until the next read at 0x10, whatever the live count does.
- R7: A write (sel=1, wr=1) at 0x08 loads the live seconds from `bus_wdata` and clears the milliseconds and the fractional phase. It takes precedence over a source pulse in the same cycle.
- R8: Writes at any offset other than 0x08 change nothing. Reads at unmapped offsets return 0.
- R9: When a read at 0x10 coincides with the pulse that rolls the milliseconds over, the returned milliseconds (999) and the captured snapshot both hold the values from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| src_tick | input | 1 | One-cycle pulse per 32.768 kHz source period |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
The counters are driven with long unbroken runs of source pulses. Some runs stop just short of the 33rd pulse and some stop exactly on it, which separates an exact fractional divider from a truncated divide-by-32 or divide-by-33. Runs of exactly 32768 pulses, started from zero and from 0xFFFFFFFF, check the seconds carry and the 32-bit rollover. Single pulses placed in the same cycle as a milliseconds read or a seconds write check which action wins on a shared edge. Snapshot reads taken after the live seconds have moved on show whether capture happens only on a milliseconds read.

// File: rtl/ms_rtc.sv
module ms_rtc #(
  parameter int SRC_HZ   = 32768,
  parameter int TICK_HZ  = 1000,
  parameter int MS_PER_S = 1000,
  parameter int SEC_W    = 32,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter logic [ADDR_W-1:0] SEC_OFS = 8'h08,
  parameter logic [ADDR_W-1:0] SHD_OFS = 8'h0c,
  parameter logic [ADDR_W-1:0] MS_OFS  = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_tick,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int ACC_W = $clog2(SRC_HZ + TICK_HZ + 1);
  localparam int MS_W  = $clog2(MS_PER_S);

  logic [ACC_W-1:0] acc_q;
  logic [MS_W-1:0]  ms_q;
  logic [SEC_W-1:0] sec_q, shadow_q;
  logic [DATA_W-1:0] rd_mux;

  wire [ACC_W-1:0] acc_sum = acc_q + ACC_W'(TICK_HZ);
  wire ms_tick = src_tick && (acc_sum >= ACC_W'(SRC_HZ));
  wire ms_last = (ms_q == MS_W'(MS_PER_S - 1));
  wire rd      = bus_sel && !bus_wr;
  wire sec_wr  = bus_sel && bus_wr && (bus_addr == SEC_OFS);
  wire ms_rd   = rd && (bus_addr == MS_OFS);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       acc_q <= '0;
    else if (sec_wr)  acc_q <= '0;
    else if (src_tick) acc_q <= ms_tick ? acc_sum - ACC_W'(SRC_HZ) : acc_sum;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       ms_q <= '0;
    else if (sec_wr)  ms_q <= '0;
    else if (ms_tick) ms_q <= ms_last ? '0 : ms_q + MS_W'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  sec_q <= '0;
    else if (sec_wr)             sec_q <= bus_wdata[SEC_W-1:0];
    else if (ms_tick && ms_last) sec_q <= sec_q + SEC_W'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     shadow_q <= '0;
    else if (ms_rd) shadow_q <= sec_q;

  always_comb begin
    rd_mux = '0;
    if (bus_addr == SEC_OFS)      rd_mux = DATA_W'(sec_q);
    else if (bus_addr == SHD_OFS) rd_mux = DATA_W'(shadow_q);
    else if (bus_addr == MS_OFS)  rd_mux = DATA_W'(ms_q);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)  bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_mux;

  assert_ms_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ms_q < MS_W'(MS_PER_S));

  assert_phase_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < ACC_W'(SRC_HZ));

  assert_sec_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sec_wr |=> (sec_q == $past(bus_wdata[SEC_W-1:0])) && (ms_q == '0) && (acc_q == '0));

  assert_snap_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ms_rd |=> shadow_q == $past(sec_q));

  assert_snap_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ms_rd |=> $stable(shadow_q));

  assert_sec_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_wr |=> ($stable(sec_q) || ((sec_q == $past(sec_q) + SEC_W'(1)) && (ms_q == '0))));

  assert_rdata_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(bus_rdata));
endmodule

// File: tb/ms_rtc_tb.sv
module ms_rtc_tb;
  localparam int CLK_P = 10;
  localparam logic [7:0] A_SEC = 8'h08, A_SHD = 8'h0c, A_MS = 8'h10;

  logic clk = 0, rst_n = 0, src_tick = 0, bus_sel = 0, bus_wr = 0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;

  int checks = 0, fails = 0;
  longint n_ticks = 0;
  logic [31:0] base_sec = 0, shadow_m = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic rd_d = 0, done = 0;

  always #(CLK_P/2) clk = ~clk;

  ms_rtc u_dut (.clk(clk), .rst_n(rst_n), .src_tick(src_tick), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  function automatic longint total_ms(); return (n_ticks * 1000) / 32768; endfunction
  function automatic logic [31:0] cur_ms(); return 32'(total_ms() % 1000); endfunction
  function automatic logic [31:0] cur_sec(); return base_sec + 32'(total_ms() / 1000); endfunction

  always @(posedge clk) rd_d <= bus_sel && !bus_wr;

  always @(negedge clk) if (rd_d) begin
    checks++;
    if (exp_q.size() == 0) begin
      fails++; $display("FAIL unexpected read result act=%h exp=none", bus_rdata);
    end else begin
      logic [31:0] e; string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      if (bus_rdata !== e) begin
        fails++; $display("FAIL %s act=%h exp=%h", t, bus_rdata, e);
      end
    end
  end

  task automatic run_ticks(input int n);
    src_tick = 1; repeat (n) @(negedge clk); src_tick = 0; n_ticks += n;
  endtask

  task automatic rd(input logic [7:0] a, input logic t, input string tag);
    logic [31:0] e;
    if (a == A_SEC) e = cur_sec();
    else if (a == A_SHD) e = shadow_m;
    else if (a == A_MS) begin e = cur_ms(); shadow_m = cur_sec(); end
    else e = 0;
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_sel = 1; bus_wr = 0; bus_addr = a; src_tick = t;
    @(negedge clk);
    bus_sel = 0; src_tick = 0;
    if (t) n_ticks++;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic t);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; src_tick = t;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; src_tick = 0;
    if (a == A_SEC) begin base_sec = d; n_ticks = 0; end
    else if (t) n_ticks++;
  endtask

  task automatic finish_run();
    @(negedge clk); @(negedge clk);
    if (exp_q.size() != 0) begin
      fails++; $display("FAIL R5 pending reads act=%0d exp=0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_P * 190000);
    fails++; $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (bus_rdata !== 32'h0) begin fails++; $display("FAIL R1 rdata act=%h exp=0", bus_rdata); end
    rd(A_SEC, 0, "R1 live seconds after reset");
    rd(A_SHD, 0, "R1 snapshot after reset");
    rd(A_MS,  0, "R1 ms after reset");

    run_ticks(32);
    rd(A_MS, 0, "R2 ms after 32 pulses");
    run_ticks(1);
    rd(A_MS, 0, "R2 ms after 33 pulses");
    run_ticks(16384 - 33);
    rd(A_MS, 0, "R2 ms at half second");
    rd(A_SHD, 0, "R5 snapshot read");
    run_ticks(16384);
    rd(A_SEC, 0, "R3 seconds after 32768 pulses");
    rd(A_SHD, 0, "R6 snapshot kept old value");
    rd(A_MS, 0, "R3 ms wrapped to zero");
    rd(A_SHD, 0, "R6 snapshot recaptured");

    run_ticks(500);
    wr(A_SEC, 32'd100, 1);
    rd(A_SEC, 0, "R7 seconds loaded");
    rd(A_MS, 0, "R7 ms cleared");
    run_ticks(32);
    rd(A_MS, 0, "R7 phase cleared, 32 pulses");
    run_ticks(1);
    rd(A_MS, 0, "R7 phase cleared, 33 pulses");

    wr(A_MS, 32'd55, 0);
    wr(A_SHD, 32'd77, 0);
    wr(8'h14, 32'hdead, 0);
    rd(A_MS, 0, "R8 ms unchanged by write");
    rd(A_SHD, 0, "R8 snapshot unchanged by write");
    rd(A_SEC, 0, "R8 seconds unchanged");
    rd(8'h00, 0, "R8 unmapped 0x00");
    rd(8'h14, 0, "R8 unmapped 0x14");

    wr(A_SEC, 32'hffff_ffff, 0);
    run_ticks(32767);
    rd(A_MS, 1, "R9 ms read on rollover pulse");
    rd(A_SHD, 0, "R9 snapshot holds pre-rollover seconds");
    rd(A_SEC, 0, "R4 seconds rolled to zero");
    rd(A_MS, 0, "R4 ms zero after rollover");
    run_ticks(40);
    rd(A_MS, 0, "R2 ms after rollover");
    finish_run();
  end
endmodule